// File: doc/BRIEF.md
# Endian-Selectable Transmit Buffer Byte Unpacker

This block turns a frame stored in a 32-bit-wide buffer memory into a byte stream for a byte-serial transmit MAC. A command gives a page number and a byte count. The block skips the first word of the page, because that word is kept for the status word. It then reads words in ascending address order and hands out bytes one at a time on a valid/ready stream. A two-entry word queue lets it read the next word before the current word is used up. If the consumer keeps ready high, a new byte is therefore offered on every cycle.

A configuration bit sets the byte order inside each word. With the bit at 0 (little-endian), the least significant byte goes first. With the bit at 1 (big-endian), the most significant byte goes first. After the last byte, the block writes a 32-bit status word into the reserved first word of the page, using the same byte order. It then pulses done.

The memory port is shared with a byte-wide host port. An external arbiter grants each request. A request that is not granted stays asserted and unchanged until the grant arrives.

Top module: `tx_buf_unpacker`

## Requirements
- R1: After reset, `out_valid_o`, `mem_req_o` and `done_o` are all low.
- R2: A frame of length L on page P reads exactly ceil(L/4) words. The first read is at word address P*64+1, and each later read is at the previous read address plus one.
- R3: With the order bit latched as 0, frame byte k is bits [8*(k mod 4)+7 : 8*(k mod 4)] of word P*64+1+floor(k/4).
- R4: With the order bit latched as 1, frame byte k is bits [8*(3-k mod 4)+7 : 8*(3-k mod 4)] of that same word.
- R5: Exactly L bytes are emitted per frame. The unused lanes of a final word that is only partly filled are dropped.
- R6: While `out_valid_o` is high and `out_ready_i` is low, the next cycle keeps `out_valid_o` high and `out_data_o` unchanged.
- R7: After the last byte, exactly one write goes to word address P*64. The write data is `stat_i` as given when the order bit is 0, and `stat_i` with its four bytes reversed when the bit is 1. `done_o` is high for exactly one cycle, the cycle after that write is granted.
- R8: A length of 0 issues no reads and emits no bytes, then goes straight to the status write and `done_o`.
- R9: A `start_i` that arrives while a command is in progress is dropped. It changes nothing in the current frame and does not run afterwards.
- R10: A read request that is not granted stays asserted, with the same address, in the next cycle.
- R11: With `mem_gnt_i` and `out_ready_i` held high, `out_valid_o` does not drop between the first and the last byte of a frame.
- R12: `page_i`, `len_i` and `cfg_be_i` are captured when a start is accepted. Changing `cfg_be_i` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_be_i | input | 1 | Byte order: 0 = little-endian, 1 = big-endian |
| start_i | input | 1 | Start request; taken only when idle |
| page_i | input | PAGE_W (5) | Starting page |
| len_i | input | LEN_W (13) | Frame length in bytes |
| out_valid_o | output | 1 | Byte stream valid |
| out_ready_i | input | 1 | Byte stream ready |
| out_data_o | output | 8 | Byte stream data |
| stat_valid_i | input | 1 | Status word is available for write-back |
| stat_i | input | 32 | Status word |
| done_o | output | 1 | One-cycle strobe when the command has finished |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable (1 only for the status write) |
| mem_addr_o | output | PAGE_W+6 (11) | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Arbiter grant for the current request |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a granted read |

## Verification
The checker watches the memory port and the byte stream on every cycle. It checks that read addresses step by one from page base plus one. It checks that a denied read is held, that a stalled byte holds still, that a write goes only to a page base, and that done follows a granted write and lasts one cycle. The byte values in each lane order, the exact byte and read counts, the reversed status word, and the dropping of a start that arrives while busy all depend on the frame contents, so only the bench shows them. It does this with sweeps over lengths and pages, under random stalls on the grant and ready inputs. The bench alone measures the gap-free stream when the grant and ready inputs are held high.

// File: rtl/tx_unpack_pkg.sv
package tx_unpack_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES);
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STREAM,
    ST_STAT,
    ST_DONE
  } unp_state_e;
endpackage

// File: rtl/tx_word_fetch.sv
module tx_word_fetch #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  nwords_i,
  input  logic              en_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              gnt_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic              pop_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = PTR_W + 2;
  localparam logic [OCC_W-1:0] DEPTH_L = OCC_W'(DEPTH);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              pend_q;
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [PTR_W:0]    cnt_q;
  logic [WORD_W-1:0] buf_q [DEPTH];
  logic [OCC_W-1:0]  occ;
  logic              grant, push, pop;

  // in-flight read counts against queue space
  assign occ    = {1'b0, cnt_q} + {{(OCC_W-1){1'b0}}, pend_q};
  assign req_o  = en_i && (left_q != '0) && (occ < DEPTH_L);
  assign addr_o = addr_q;
  assign grant  = req_o && gnt_i;
  assign push   = pend_q;
  assign pop    = pop_i && (cnt_q != '0);
  assign vld_o  = (cnt_q != '0);
  assign word_o = buf_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
      pend_q <= 1'b0;
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      left_q <= nwords_i;
      pend_q <= 1'b0;
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= grant;
      if (grant) begin
        addr_q <= addr_q + ADDR_W'(1);
        left_q <= left_q - CNT_W'(1);
      end
      if (push) wp_q <= wp_q + PTR_W'(1);
      if (pop)  rp_q <= rp_q + PTR_W'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + (PTR_W+1)'(1);
        2'b01:   cnt_q <= cnt_q - (PTR_W+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) buf_q[wp_q] <= rdata_i;
  end
endmodule

// File: rtl/tx_lane_sel.sv
module tx_lane_sel #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 2
) (
  input  logic [8*LANES-1:0] word_i,
  input  logic [LANE_W-1:0]  lane_i,
  input  logic               be_i,
  output logic [7:0]         byte_o
);
  logic [7:0]        lanes [LANES];
  logic [LANE_W-1:0] sel;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lanes[l] = word_i[8*l +: 8];
  end

  // big-endian: wire order starts at the top lane
  assign sel    = be_i ? (LANE_W'(LANES - 1) - lane_i) : lane_i;
  assign byte_o = lanes[sel];
endmodule

// File: rtl/tx_stat_pack.sv
module tx_stat_pack #(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0] word_i,
  input  logic               be_i,
  output logic [8*LANES-1:0] word_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_swap
    assign word_o[8*l +: 8] = be_i ? word_i[8*(LANES-1-l) +: 8] : word_i[8*l +: 8];
  end
endmodule

// File: rtl/tx_buf_unpacker.sv
module tx_buf_unpacker
  import tx_unpack_pkg::*;
#(
  parameter int unsigned PAGE_W     = 5,
  parameter int unsigned PAGE_LOG2  = 8,
  parameter int unsigned LEN_W      = 13,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_be_i,
  input  logic                          start_i,
  input  logic [PAGE_W-1:0]             page_i,
  input  logic [LEN_W-1:0]              len_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [7:0]                    out_data_o,
  input  logic                          stat_valid_i,
  input  logic [WORD_W-1:0]             stat_i,
  output logic                          done_o,
  output logic                          mem_req_o,
  output logic                          mem_we_o,
  output logic [PAGE_W+PAGE_LOG2-3:0]   mem_addr_o,
  output logic [WORD_W-1:0]             mem_wdata_o,
  input  logic                          mem_gnt_i,
  input  logic [WORD_W-1:0]             mem_rdata_i
);
  localparam int unsigned WIDX_W = PAGE_LOG2 - LANE_W;
  localparam int unsigned ADDR_W = PAGE_W + WIDX_W;
  localparam int unsigned NW_W   = LEN_W + 1 - LANE_W;

  unp_state_e          state_q;
  logic [PAGE_W-1:0]   page_q;
  logic                be_q;
  logic [LEN_W-1:0]    left_q;
  logic [LANE_W-1:0]   lane_q;

  logic                accept, hs, last_byte, pop;
  logic [LEN_W:0]      len_rnd;
  logic [NW_W-1:0]     nwords;
  logic [ADDR_W-1:0]   base_addr;
  logic                f_req, f_vld;
  logic [ADDR_W-1:0]   f_addr;
  logic [WORD_W-1:0]   f_word, stat_packed;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign len_rnd   = {1'b0, len_i} + (LEN_W+1)'(WORD_BYTES - 1);
  assign nwords    = len_rnd[LEN_W:LANE_W];
  assign base_addr = {page_i, WIDX_W'(1)};  // word 0 holds status

  tx_word_fetch #(
    .ADDR_W (ADDR_W),
    .CNT_W  (NW_W),
    .WORD_W (WORD_W),
    .DEPTH  (FIFO_DEPTH)
  ) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .base_i   (base_addr),
    .nwords_i (nwords),
    .en_i     (state_q == ST_STREAM),
    .req_o    (f_req),
    .addr_o   (f_addr),
    .gnt_i    (mem_gnt_i),
    .rdata_i  (mem_rdata_i),
    .pop_i    (pop),
    .vld_o    (f_vld),
    .word_o   (f_word)
  );

  tx_lane_sel #(
    .LANES  (WORD_BYTES),
    .LANE_W (LANE_W)
  ) u_lane (
    .word_i (f_word),
    .lane_i (lane_q),
    .be_i   (be_q),
    .byte_o (out_data_o)
  );

  tx_stat_pack #(
    .LANES (WORD_BYTES)
  ) u_pack (
    .word_i (stat_i),
    .be_i   (be_q),
    .word_o (stat_packed)
  );

  assign out_valid_o = (state_q == ST_STREAM) && f_vld;
  assign hs          = out_valid_o && out_ready_i;
  assign last_byte   = (left_q == LEN_W'(1));
  assign pop         = hs && ((lane_q == LANE_W'(WORD_BYTES - 1)) || last_byte);

  assign mem_req_o   = (state_q == ST_STAT) ? stat_valid_i : f_req;
  assign mem_we_o    = (state_q == ST_STAT);
  assign mem_addr_o  = (state_q == ST_STAT) ? {page_q, WIDX_W'(0)} : f_addr;
  assign mem_wdata_o = stat_packed;
  assign done_o      = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      be_q    <= 1'b0;
      left_q  <= '0;
      lane_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            page_q  <= page_i;
            be_q    <= cfg_be_i;
            left_q  <= len_i;
            lane_q  <= '0;
            state_q <= (len_i == '0) ? ST_STAT : ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (hs) begin
            left_q <= left_q - LEN_W'(1);
            lane_q <= lane_q + LANE_W'(1);
            if (last_byte) state_q <= ST_STAT;
          end
        end
        ST_STAT: begin
          if (stat_valid_i && mem_gnt_i) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_buf_unpacker_chk.sv
module tx_buf_unpacker_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned WIDX_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              accept_i,
  input logic              busy_i,
  input logic              out_valid_i,
  input logic              out_ready_i,
  input logic [7:0]        out_data_i,
  input logic              done_i,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_i
);
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;
  logic              rd_gnt;

  assign rd_gnt = mem_req_i && !mem_we_i && mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (accept_i) begin
      seen_q <= 1'b0;
    end else if (rd_gnt) begin
      seen_q <= 1'b1;
      last_q <= mem_addr_i;
    end
  end

  // R2
  first_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gnt && !seen_q) |-> (mem_addr_i[WIDX_W-1:0] == WIDX_W'(1)));

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gnt && seen_q) |-> (mem_addr_i == last_q + ADDR_W'(1)));

  // R6
  hold_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(out_data_i)));

  // R10
  hold_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_we_i && !mem_gnt_i) |=> (mem_req_i && $stable(mem_addr_i)));

  // R7
  stat_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_we_i) |-> (mem_addr_i[WIDX_W-1:0] == '0));

  // R7
  done_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(mem_req_i && mem_we_i && mem_gnt_i));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R5
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> busy_i);
endmodule

bind tx_buf_unpacker tx_buf_unpacker_chk #(
  .ADDR_W (ADDR_W),
  .WIDX_W (WIDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .accept_i    (accept),
  .busy_i      (state_q != ST_IDLE),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_i  (out_data_o),
  .done_i      (done_o),
  .mem_req_i   (mem_req_o),
  .mem_we_i    (mem_we_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_i  (mem_addr_o)
);

// File: tb/tx_buf_unpacker_bench.sv
module tx_buf_unpacker_bench;
  localparam int PAGE_W = 5;
  localparam int LEN_W  = 13;
  localparam int ADDR_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              cfg_be = 1'b0, start = 1'b0, stat_valid = 1'b0;
  logic [PAGE_W-1:0] page = '0;
  logic [LEN_W-1:0]  len = '0;
  logic [31:0]       stat = '0;
  logic              out_valid, done, mem_req, mem_we;
  logic [7:0]        out_data;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata, mem_rdata = '0;
  logic              ready_r = 1'b0, gnt_r = 1'b0;

  tx_buf_unpacker u_tx_buf_unpacker (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_be_i     (cfg_be),
    .start_i      (start),
    .page_i       (page),
    .len_i        (len),
    .out_valid_o  (out_valid),
    .out_ready_i  (ready_r),
    .out_data_o   (out_data),
    .stat_valid_i (stat_valid),
    .stat_i       (stat),
    .done_o       (done),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_gnt_i    (gnt_r),
    .mem_rdata_i  (mem_rdata)
  );

  int n_tests = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  int rx_tot = 0, stall_tot = 0, err_tot = 0;
  int rx0 = 0, cur_page = 0, cur_len = 0;
  bit cur_be = 1'b0, slow = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit pv_valid = 0, pv_ready = 0, pv_rreq = 0, pv_gnt = 0;
  logic [7:0] pv_data = '0;
  logic [ADDR_W-1:0] pv_addr = '0;

  function automatic logic [31:0] word_val(logic [ADDR_W-1:0] a);
    logic [7:0] b = a[7:0];
    logic [7:0] h = a[10:3];
    return {b ^ 8'hA5, h + 8'h3C, ~b, b + 8'h11};
  endfunction

  function automatic logic [7:0] exp_byte(int pg, int idx, bit be);
    logic [ADDR_W-1:0] a = ADDR_W'(pg * 64 + 1 + idx / 4);
    int ln = be ? 3 - (idx % 4) : idx % 4;
    logic [31:0] w = word_val(a);
    return w[8*ln +: 8];
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model: sync read, write recorder
  always @(posedge clk) begin
    if (mem_req && gnt_r) begin
      if (mem_we) begin
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_addr;
        wr_data <= mem_wdata;
      end else begin
        rd_cnt    <= rd_cnt + 1;
        mem_rdata <= word_val(mem_addr);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pv_valid && !pv_ready)
        chk(out_valid && out_data == pv_data, "R6 held byte", {24'h0, out_data}, {24'h0, pv_data});
      if (pv_rreq && !pv_gnt)
        chk(mem_req && mem_addr == pv_addr, "R10 held read", {21'h0, mem_addr}, {21'h0, pv_addr});
      if (!slow && (rx_tot - rx0) > 0 && (rx_tot - rx0) < cur_len && !out_valid)
        stall_tot++;
    end
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready_r = slow ? (lfsr[0] | lfsr[3]) : 1'b1;
    gnt_r   = slow ? (lfsr[5] | lfsr[1]) : 1'b1;
    if (rst_n && out_valid && ready_r) begin
      logic [7:0] e;
      e = exp_byte(cur_page, rx_tot - rx0, cur_be);
      if (out_data != e) err_tot++;
      chk(out_data == e, cur_be ? "R4 big-endian byte" : "R3 little-endian byte",
          {24'h0, out_data}, {24'h0, e});
      rx_tot++;
    end
    pv_valid = out_valid;
    pv_ready = ready_r;
    pv_data  = out_data;
    pv_rreq  = mem_req && !mem_we;
    pv_gnt   = gnt_r;
    pv_addr  = mem_addr;
  end

  task automatic run_frame(int pg, int ln, bit be, bit slow_m, bit poke, bit flip);
    int rd0, wr0, st0, er0, t;
    logic [31:0] s, ps;
    s  = 32'hC0000000 | (pg << 16) | (ln << 2) | 32'h3;
    ps = be ? {s[7:0], s[15:8], s[23:16], s[31:24]} : s;
    @(negedge clk);
    slow = slow_m; cur_page = pg; cur_len = ln; cur_be = be;
    rx0 = rx_tot; rd0 = rd_cnt; wr0 = wr_cnt; st0 = stall_tot; er0 = err_tot;
    stat = s; stat_valid = 1'b1;
    cfg_be = be; page = PAGE_W'(pg); len = LEN_W'(ln); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (flip) cfg_be = ~be;
    if (poke) begin
      repeat (2) @(negedge clk);
      page = PAGE_W'(pg ^ 1); len = LEN_W'(7); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R7 done reached", {31'h0, done}, 32'h1);
    chk(rx_tot - rx0 == ln, "R5 byte count", rx_tot - rx0, ln);
    chk(rd_cnt - rd0 == (ln + 3) / 4, "R2 read count", rd_cnt - rd0, (ln + 3) / 4);
    chk(wr_cnt - wr0 == 1, "R7 status write count", wr_cnt - wr0, 1);
    chk(wr_addr == ADDR_W'(pg * 64), "R7 status address", {21'h0, wr_addr}, pg * 64);
    chk(wr_data == ps, "R7 status data", wr_data, ps);
    if (ln == 0) chk(rd_cnt - rd0 == 0 && rx_tot - rx0 == 0, "R8 empty frame", rd_cnt - rd0, 0);
    if (!slow_m) chk(stall_tot - st0 == 0, "R11 gap-free stream", stall_tot - st0, 0);
    if (flip) chk(err_tot - er0 == 0, "R12 order latched", err_tot - er0, 0);
    @(negedge clk);
    chk(!done, "R7 done one cycle", {31'h0, done}, 0);
    stat_valid = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(!out_valid && !mem_req, "R9 busy start dropped", {30'h0, out_valid, mem_req}, 0);
    end
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R5 watchdog expired act=running exp=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !mem_req && !done, "R1 in reset", {29'h0, out_valid, mem_req, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !mem_req && !done, "R1 after reset", {29'h0, out_valid, mem_req, done}, 0);
    for (int be = 0; be < 2; be++)
      for (int ln = 0; ln < 13; ln++)
        run_frame((ln * 3 + be * 7) % 32, ln, bit'(be), 1'b1, 1'b0, 1'b0);
    for (int be = 0; be < 2; be++) begin
      run_frame(31, 250, bit'(be), 1'b0, 1'b0, 1'b0);
      run_frame(0, 9, bit'(be), 1'b0, 1'b0, 1'b0);
      run_frame(17, 37, bit'(be), 1'b1, 1'b0, 1'b0);
    end
    run_frame(4, 40, 1'b1, 1'b1, 1'b1, 1'b0);
    run_frame(9, 21, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame(12, 22, 1'b1, 1'b1, 1'b0, 1'b1);
    finish_up();
  end
endmodule